// File: doc/BRIEF.md
# Multi-Channel Completion Status Queue

This block gathers completion reports from four command channels and holds them in a single ordered queue that a host drains over a simple register port. When a channel finishes a command, it raises a request that carries a 6-bit host status code and an 8-bit device status. The channel keeps that request up until the block acknowledges it. When more than one channel requests in the same cycle, a round-robin arbiter picks which report enters the queue first.

The host reads the head entry as two 32-bit words. The lower word carries the device status. The upper word carries the channel number, the host status, a valid flag and an empty flag. Reading the upper word removes the entry, so the host drains the queue by reading pairs of words until the empty flag is set. A single interrupt line is high while the queue holds entries, provided the host has enabled it through a mask register. A sticky overflow output records that a channel was made to wait because the queue was full.

Top module: `cmpl_status_queue`

## Requirements
- R1: A read at address 0x100 returns the head entry's device status in bits 23:16 and zeros in all other bits. The whole word is zero when the queue is empty.
- R2: A read at address 0x104 returns: bit 31 set when the queue is empty, bit 30 set when an entry is present, bits 9:8 the channel number (0 to 3), bits 5:0 the host status, and zeros in all other bits. The host status is stored as given, so code 0 (success) and code 3 (device error) pass through unchanged.
- R3: A read at 0x104 while an entry is present removes that entry. A read at 0x100 removes nothing.
- R4: A read at 0x104 while the queue is empty returns exactly 0x8000_0000 and changes no state.
- R5: The queue holds 16 entries and returns them in the order they were accepted.
- R6: When several channels request together, grants rotate round-robin. The search starts at the channel after the one granted last, wrapping from 3 to 0, and starts at channel 0 after reset.
- R7: A request is accepted in the cycle its ack is high. Ack is one-hot or zero, goes only to a requesting channel, and stays low while the queue is full.
- R8: The overflow output rises after a cycle in which any request is present while the queue is full. It then stays high until reset.
- R9: Bit 0 of the mask register at address 0xE4 enables the interrupt (write 1) or disables it (write 0). The register reads back in bit 0, and it is 0 after reset.
- R10: The interrupt is high exactly when the mask bit is 1 and the queue is not empty.
- R11: After reset the queue is empty, every ack is low, the interrupt is low and the overflow output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_req | input | 4 | Completion request for each channel, held until acked |
| ch_hst | input | 24 | Host status per channel, 6 bits each, channel 0 in the low bits |
| ch_dst | input | 32 | Device status per channel, 8 bits each, channel 0 in the low bits |
| ch_ack | output | 4 | Request accepted this cycle |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 12 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid in the cycle of the strobe |
| irq | output | 1 | Global interrupt |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The checker watches the following on every cycle:
- ack is one-hot or zero and goes only to a requesting channel;
- no ack is given while the queue is full;
- the two flags in the upper word always disagree;
- the overflow flag, once high, stays high;
- the interrupt follows the mask bit and the fill level;
- every read of the upper word that removes an entry lowers the fill by one.

Only the bench scenarios can show the rest:
- field placement across all 64 host status codes;
- first-in first-out order over a full queue;
- the exact grant order after the rotation pointer has been moved;
- reading the lower word without removing the entry.

// File: rtl/csq_pkg.sv
// Shared types and address map of the completion status queue.
package csq_pkg;
    localparam int CHW = 2;   // channel field width in an entry
    localparam int HSW = 6;   // host status width
    localparam int DSW = 8;   // device status width
    localparam int BAW = 12;  // host address width

    localparam logic [BAW-1:0] ADDR_LO   = 12'h100;
    localparam logic [BAW-1:0] ADDR_HI   = 12'h104;
    localparam logic [BAW-1:0] ADDR_MASK = 12'h0E4;

    typedef struct packed {
        logic [CHW-1:0] chan;
        logic [HSW-1:0] hst;
        logic [DSW-1:0] dst;
    } entry_t;
endpackage

// File: rtl/csq_rr_arb.sv
// Round-robin arbiter. Grants at most one requester per cycle, searching
// upward from the channel after the last grant. Assumes the caller gates
// grants with en when the destination cannot accept.
module csq_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr_q;

    // Pick the first requester at or after the rotation pointer.
    always_comb begin
        logic found;
        int   idx;
        gnt   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            idx = (int'(ptr_q) + i) % N;
            if (!found && en && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    // Move the pointer past the channel just granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            for (int c = 0; c < N; c++) begin
                if (gnt[c]) ptr_q <= PW'((c + 1) % N);
            end
        end
    end
endmodule

// File: rtl/csq_fifo.sv
// Synchronous first-in first-out store with a show-ahead head. The caller
// must not push when full or pop when empty.
module csq_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     fill
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   cnt;

    // Store incoming entries.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= (int'(wr_ptr) == DEPTH - 1) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (int'(rd_ptr) == DEPTH - 1) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign full  = (cnt == (AW+1)'(DEPTH));
    assign empty = (cnt == '0);
    assign fill  = cnt;
endmodule

// File: rtl/cmpl_status_queue.sv
// Completion status queue top. Channels hold requests until acked; the host
// reads entries as two words, the upper-word read popping the head.
// Assumes NCH <= 4 so the channel number fits the 2-bit entry field.
module cmpl_status_queue
    import csq_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     ch_req,
    input  logic [NCH*HSW-1:0] ch_hst,
    input  logic [NCH*DSW-1:0] ch_dst,
    output logic [NCH-1:0]     ch_ack,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [BAW-1:0]     bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq,
    output logic               ovf
);
    localparam int W  = $bits(entry_t);
    localparam int FW = $clog2(DEPTH) + 1;

    logic          full, empty, push, pop, mask_q, ovf_q;
    logic [FW-1:0] fill;
    logic [W-1:0]  head_raw;
    entry_t        head, new_ent;

    csq_rr_arb #(.N(NCH)) u_arb (
        .clk(clk), .rst_n(rst_n), .en(!full), .req(ch_req), .gnt(ch_ack)
    );

    // Build the entry for the granted channel.
    always_comb begin
        new_ent = '0;
        for (int c = 0; c < NCH; c++) begin
            if (ch_ack[c]) begin
                new_ent.chan = CHW'(c);
                new_ent.hst  = ch_hst[c*HSW +: HSW];
                new_ent.dst  = ch_dst[c*DSW +: DSW];
            end
        end
    end

    assign push = |ch_ack;
    assign pop  = bus_rd && (bus_addr == ADDR_HI) && !empty;

    csq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(new_ent), .pop(pop),
        .head(head_raw), .full(full), .empty(empty), .fill(fill)
    );
    assign head = entry_t'(head_raw);

    // Interrupt mask register and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == ADDR_MASK) mask_q <= bus_wdata[0];
            if (full && |ch_req) ovf_q <= 1'b1;
        end
    end

    // Host read data mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                ADDR_LO: if (!empty) bus_rdata[23:16] = head.dst;
                ADDR_HI: begin
                    bus_rdata[31] = empty;
                    bus_rdata[30] = !empty;
                    if (!empty) begin
                        bus_rdata[9:8] = head.chan;
                        bus_rdata[5:0] = head.hst;
                    end
                end
                ADDR_MASK: bus_rdata[0] = mask_q;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq = mask_q && !empty;
    assign ovf = ovf_q;
endmodule

// File: rtl/csq_checker.sv
// Cycle-by-cycle properties of the completion status queue, bound to the top.
module csq_checker
    import csq_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DEPTH = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCH-1:0]         ch_req,
    input logic [NCH-1:0]         ch_ack,
    input logic                   bus_rd,
    input logic [BAW-1:0]         bus_addr,
    input logic [31:0]            bus_rdata,
    input logic                   irq,
    input logic                   ovf,
    input logic                   mask_q,
    input logic [$clog2(DEPTH):0] fill
);
    localparam int FW = $clog2(DEPTH) + 1;

    p_ack_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_ack));
    p_ack_requested_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_ack & ~ch_req) == '0);
    p_no_ack_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == FW'(DEPTH)) |-> (ch_ack == '0));
    p_flags_differ_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_HI) |-> (bus_rdata[31] != bus_rdata[30]));
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q |-> !irq);
    p_irq_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q && fill != '0) |-> irq);
    p_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_HI && fill != '0 && ch_ack == '0)
        |=> (fill == $past(fill) - 1'b1));
endmodule

bind cmpl_status_queue csq_checker #(.NCH(NCH), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_ack(ch_ack),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .irq(irq), .ovf(ovf), .mask_q(mask_q), .fill(fill)
);

// File: tb/sim_cmpl_status_queue.sv
// Self-checking bench: sweeps host status codes, arbitration orders,
// a full queue and the interrupt mask.
module sim_cmpl_status_queue;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic [3:0]  ch_req = '0;
    logic [23:0] ch_hst = '0;
    logic [31:0] ch_dst = '0;
    logic [3:0]  ch_ack;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq, ovf;

    int checks = 0, fails = 0;
    int order_q [16];
    int n_order;

    always #10 clk = ~clk;

    cmpl_status_queue u0 (
        .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_hst(ch_hst),
        .ch_dst(ch_dst), .ch_ack(ch_ack), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .ovf(ovf)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read one word; pops take effect at the following edge.
    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Hold the given requests until each is acked; log grant order.
    task automatic run_reqs(input logic [3:0] r);
        logic [3:0] pend = r;
        n_order = 0;
        while (pend != 0) begin
            ch_req = pend;
            #1;
            for (int c = 0; c < 4; c++)
                if (ch_ack[c]) begin order_q[n_order] = c; n_order++; pend[c] = 1'b0; end
            @(posedge clk); @(negedge clk);
        end
        ch_req = '0;
    endtask

    task automatic set_ch(input int c, input logic [5:0] h, input logic [7:0] d);
        ch_hst[c*6 +: 6] = h;
        ch_dst[c*8 +: 8] = d;
    endtask

    function automatic logic [31:0] hi_word(input int c, input logic [5:0] h);
        return 32'h4000_0000 | (32'(c) << 8) | 32'(h);
    endfunction

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 / R4 reset state
        check("R11 irq", {31'b0, irq}, 0);
        check("R11 ovf", {31'b0, ovf}, 0);
        check("R11 ack", {28'b0, ch_ack}, 0);
        rd(12'h104, d); check("R4 empty hi", d, 32'h8000_0000);
        rd(12'h104, d); check("R4 empty again", d, 32'h8000_0000);
        rd(12'h100, d); check("R1 empty lo", d, 0);
        rd(12'h0E4, d); check("R9 mask reset", d, 0);

        // R1 R2 R3: all 64 host codes, channel = code mod 4
        for (int h = 0; h < 64; h++) begin
            logic [7:0] dv = 8'(h * 5 + 7);
            set_ch(h % 4, 6'(h), dv);
            run_reqs(4'(1 << (h % 4)));
            rd(12'h100, d); check("R1 lo", d, {8'h0, dv, 16'h0});
            rd(12'h100, d); check("R3 lo no pop", d, {8'h0, dv, 16'h0});
            rd(12'h104, d); check("R2 hi", d, hi_word(h % 4, 6'(h)));
            rd(12'h104, d); check("R3 popped", d, 32'h8000_0000);
        end

        // R6: last grant was channel 3, so order starts at 0
        for (int c = 0; c < 4; c++) set_ch(c, 6'(c == 2 ? 3 : 0), 8'(8'h10 + c));
        run_reqs(4'hF);
        for (int i = 0; i < 4; i++) begin
            check("R6 grant order", 32'(order_q[i]), 32'(i));
            rd(12'h100, d); check("R5 lo order", d, {8'h0, 8'(8'h10 + i), 16'h0});
            rd(12'h104, d); check("R6 hi order", d, hi_word(i, 6'(i == 2 ? 3 : 0)));
        end
        // grant channel 1 alone, then all: expect 2,3,0,1
        run_reqs(4'b0010);
        rd(12'h104, d); check("R2 single ch1", d, hi_word(1, 0));
        run_reqs(4'hF);
        for (int i = 0; i < 4; i++) begin
            check("R6 rotated order", 32'(order_q[i]), 32'((i + 2) % 4));
            rd(12'h104, d); check("R6 rotated hi", d, hi_word((i + 2) % 4, 6'((i + 2) % 4 == 2 ? 3 : 0)));
        end

        // R5 R7 R8: fill 16 entries, then a request must wait
        check("R8 ovf before", {31'b0, ovf}, 0);
        for (int i = 0; i < 16; i++) begin
            set_ch(0, 6'(i), 8'(i * 3));
            run_reqs(4'b0001);
        end
        ch_req = 4'b0010;
        #1 check("R7 no ack when full", {28'b0, ch_ack}, 0);
        @(posedge clk); @(negedge clk);
        ch_req = '0;
        check("R8 ovf set", {31'b0, ovf}, 1);
        check("R10 irq masked", {31'b0, irq}, 0);
        wr(12'h0E4, 32'h1);
        rd(12'h0E4, d); check("R9 mask readback", d, 1);
        check("R10 irq on", {31'b0, irq}, 1);
        for (int i = 0; i < 16; i++) begin
            rd(12'h100, d); check("R5 fifo lo", d, {8'h0, 8'(i * 3), 16'h0});
            rd(12'h104, d); check("R5 fifo hi", d, hi_word(0, 6'(i)));
        end
        rd(12'h104, d); check("R4 drained", d, 32'h8000_0000);
        check("R10 irq off empty", {31'b0, irq}, 0);
        check("R8 ovf sticky", {31'b0, ovf}, 1);

        // R10: mask off while non-empty
        run_reqs(4'b0100);
        check("R10 irq nonempty", {31'b0, irq}, 1);
        wr(12'h0E4, 32'h0);
        rd(12'h0E4, d); check("R9 mask cleared", d, 0);
        check("R10 irq masked again", {31'b0, irq}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule